// File: doc/BRIEF.md
# UART receive FIFO controller

This block receives asynchronous 8N1 serial characters from an RXD line sampled on a 16x sample enable. Each character goes into a 16-entry receive queue along with a framing-error bit for that character. A small register bus lets software pop characters, inspect sticky status flags, read how many characters are queued and set a fill trigger. An interrupt output combines a receive-ready source and an error source.

The receive-ready flag follows a programmable fill level. A separate timeout flag reports a partly filled queue once the line has been quiet for a while. Every sticky flag uses a read-then-clear discipline: a write of 0 to a flag has effect only after a status read has returned that flag as 1. Overrun is reported in its own line-status register, apart from the other error flags.

Top module: `serial_rx_fifo_ctl`

## Requirements
- R1: A character is a low start bit, 8 data bits sent LSB first and a stop bit. Characters are queued in arrival order, and a bus read of the data register (address 0) returns the oldest one and removes it.
- R2: A start bit is accepted only if at least two of the three line samples taken around its mid-point are low. A rejected start returns the receiver to idle and queues nothing.
- R3: The receive-ready flag (status bit 0) sets while the queue count is at or above the effective trigger. The trigger field is control bits [5:0]; a value of 0 acts as 1 and a value above the queue depth acts as the depth. Clearing bit 0 is covered by R12, and the clear is overridden while the count still meets the trigger.
- R4: `irq` is high when control bit 7 is 1 and either the receive-ready flag or the timeout flag is set, or when control bit 6 is 1 and any of framing error, break or overrun is set.
- R5: A stop bit sampled low sets the framing-error flag (status bit 2) and stores an error bit with that character. Status bit 4 shows the error bit of the oldest queued character, and reads 0 when the queue is empty.
- R6: A character with all data bits 0 and a low stop bit sets the break flag (status bit 3) and queues a single 0x00. Nothing more is queued until the line has gone high again.
- R7: A character that completes while the queue holds 16 entries is dropped. The overrun flag (address 2, bit 0) sets, and the queued contents and count stay as they were.
- R8: The timeout flag (status bit 1) sets when 15 bit times (240 sample ticks) pass after the last stop decision with no new start detected, provided the queue is non-empty and below the effective trigger.
- R9: Address 3 returns the number of queued characters, from 0 to 16.
- R10: A data read with the queue empty returns the last character popped, and the count stays 0.
- R11: Status bit 7 gives the synchronised RXD line level.
- R12: A write of 0 to a sticky flag (status bits 0 to 3, or line-status bit 0) clears it only if a read of that register has returned the flag as 1 since the last clear attempt. A write of 0 without such a read, and any write of 1, leave the flag unchanged.
- R13: Register map: 0 data (read pops), 1 status, 2 line status, 3 count, 4 control, which is read/write, {rx-ready interrupt enable, error interrupt enable, trigger[5:0]}, reset value 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Serial receive line, idle high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the read-then-clear discipline with a clear attempted without a prior read, with a clear issued while the fill condition still holds, and with a write of 1. A design that cleared on any write of 0 would lose the ready or overrun flag early. It also drives a 17th character into a full queue, where a faulty design would corrupt or shift the stored contents. A long break must queue exactly one zero byte and not a stream of them. Short glitches must not be taken as start bits, and a data read from an empty queue must not disturb the count or the returned value.

// File: rtl/uart_rx_pkg.sv
// Shared types for the UART receive FIFO controller.
package uart_rx_pkg;

    // Receiver bit-level state.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BRKW
    } rx_state_t;

    // One queue entry: character plus its framing-error bit.
    typedef struct packed {
        logic       err;
        logic [7:0] data;
    } rx_entry_t;

    // Register addresses.
    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_LSTAT = 3'd2;
    localparam logic [2:0] A_COUNT = 3'd3;
    localparam logic [2:0] A_CTRL  = 3'd4;

endpackage

// File: rtl/uart_rx_deser.sv
// Oversampled 8N1 deserialiser.
// Assumes OS >= 4 sample ticks per bit. It votes 2-of-3 around each bit
// mid-point, reports a frame at the stop mid-point, and holds off after a
// break until the line is high again.
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    output logic       line,
    output logic       rx_idle,
    output logic       brk_hold,
    output logic       frm_valid,
    output logic [7:0] frm_data,
    output logic       frm_err,
    output logic       frm_brk
);
    localparam int PW = $clog2(OS);
    localparam logic [PW-1:0] PH_V0  = PW'(OS/2 - 1);
    localparam logic [PW-1:0] PH_V1  = PW'(OS/2);
    localparam logic [PW-1:0] PH_DEC = PW'(OS/2 + 1);
    localparam logic [PW-1:0] PH_END = PW'(OS - 1);

    rx_state_t     st;
    logic [PW-1:0] phase;
    logic [2:0]    bitn;
    logic [7:0]    shreg;
    logic [1:0]    votes;
    logic          sync1;
    logic          maj;

    assign rx_idle  = (st == RX_IDLE);
    assign brk_hold = (st == RX_BRKW);

    // Two-flop synchroniser on the serial input, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            line  <= 1'b1;
        end else begin
            sync1 <= rxd;
            line  <= sync1;
        end
    end

    // Majority of the two stored votes and the current sample.
    always_comb maj = (votes[0] & votes[1]) | (votes[0] & line) | (votes[1] & line);

    // Bit-timing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= RX_IDLE;
            phase     <= '0;
            bitn      <= '0;
            shreg     <= '0;
            votes     <= '0;
            frm_valid <= 1'b0;
            frm_data  <= '0;
            frm_err   <= 1'b0;
            frm_brk   <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            if (tick) begin
                case (st)
                    RX_IDLE: begin
                        if (!line) begin
                            st    <= RX_START;
                            phase <= PW'(1);
                        end
                    end
                    RX_BRKW: begin
                        if (line) st <= RX_IDLE;
                    end
                    default: begin
                        phase <= (phase == PH_END) ? '0 : phase + 1'b1;
                        if (phase == PH_V0) votes[0] <= line;
                        if (phase == PH_V1) votes[1] <= line;
                        if (phase == PH_DEC) begin
                            if (st == RX_START && maj) st <= RX_IDLE;
                            if (st == RX_DATA) shreg <= {maj, shreg[7:1]};
                            if (st == RX_STOP) begin
                                frm_valid <= 1'b1;
                                frm_data  <= shreg;
                                frm_err   <= !maj;
                                frm_brk   <= !maj && (shreg == 8'h00);
                                st        <= (!maj && shreg == 8'h00) ? RX_BRKW : RX_IDLE;
                            end
                        end
                        if (phase == PH_END) begin
                            if (st == RX_START) begin
                                st   <= RX_DATA;
                                bitn <= '0;
                            end else if (st == RX_DATA) begin
                                if (bitn == 3'd7) st <= RX_STOP;
                                bitn <= bitn + 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
// Receive queue: DEPTH entries of W bits with a head-of-queue read port.
// Assumes the caller gates push when full and pop when empty.
module uart_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;

    assign head  = mem[rp];
    assign full  = (count == ($clog2(DEPTH+1))'(DEPTH));
    assign empty = (count == '0);

    // Storage write; the entries need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/uart_rx_rc_flag.sv
// One sticky flag with the read-then-clear rule. A read that sees the
// flag at 1 arms it; a later write of 0 clears it if armed and consumes
// the arming. A set in the same cycle wins over the clear.
module uart_rx_rc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic rd,
    input  logic wr,
    input  logic wbit,
    output logic q
);
    logic arm;
    logic clr;

    // A clear is accepted only while armed.
    always_comb clr = wr && !wbit && arm;

    // Flag and arming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            arm <= 1'b0;
        end else begin
            if (set)      q <= 1'b1;
            else if (clr) q <= 1'b0;
            if (clr)           arm <= 1'b0;
            else if (rd && q)  arm <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_rx_flags.sv
// Status flag bank: ready, timeout, framing error, break, overrun.
// Assumes count and trig_eff share the width CW.
module uart_rx_flags #(
    parameter int CW        = 5,
    parameter int TMO_TICKS = 240
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx_idle,
    input  logic          frm_valid,
    input  logic          frm_err,
    input  logic          frm_brk,
    input  logic          ovr_ev,
    input  logic [CW-1:0] fifo_count,
    input  logic [CW-1:0] trig_eff,
    input  logic          st_rd,
    input  logic          st_wr,
    input  logic [3:0]    st_wbits,
    input  logic          ls_rd,
    input  logic          ls_wr,
    input  logic          ls_wbit,
    output logic [3:0]    stat,
    output logic          orer
);
    localparam int TW = $clog2(TMO_TICKS + 1);
    localparam logic [TW-1:0] TMO_MAX = TW'(TMO_TICKS);

    logic [TW-1:0] tmo_cnt;
    logic          tmo_hit;
    logic [3:0]    set_ev;

    // The timeout expires on the tick that reaches the limit.
    always_comb tmo_hit = rx_idle && tick && (tmo_cnt == TMO_MAX - 1'b1);

    // Quiet-line counter; starts saturated so reset alone never fires it.
    always_ff @(posedge clk) begin
        if (!rst_n)                   tmo_cnt <= TMO_MAX;
        else if (!rx_idle || frm_valid) tmo_cnt <= '0;
        else if (tick && tmo_cnt != TMO_MAX) tmo_cnt <= tmo_cnt + 1'b1;
    end

    // Set conditions for the four status flags.
    always_comb begin
        set_ev[0] = (fifo_count >= trig_eff);
        set_ev[1] = tmo_hit && (fifo_count != '0) && (fifo_count < trig_eff);
        set_ev[2] = frm_valid && frm_err;
        set_ev[3] = frm_valid && frm_brk;
    end

    for (genvar i = 0; i < 4; i++) begin : g_stat
        uart_rx_rc_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(set_ev[i]),
            .rd(st_rd), .wr(st_wr), .wbit(st_wbits[i]), .q(stat[i])
        );
    end

    uart_rx_rc_flag u_orer (
        .clk(clk), .rst_n(rst_n), .set(ovr_ev),
        .rd(ls_rd), .wr(ls_wr), .wbit(ls_wbit), .q(orer)
    );
endmodule

// File: rtl/serial_rx_fifo_ctl.sv
// UART receive FIFO controller top: deserialiser, queue, flag bank,
// control register and register read mux. Assumes DEPTH <= 32 so the
// count and trigger fit the 8-bit registers.
module serial_rx_fifo_ctl
    import uart_rx_pkg::*;
#(
    parameter int OS       = 16,
    parameter int DEPTH    = 16,
    parameter int TMO_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_tick,
    input  logic       rxd,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    localparam int CW        = $clog2(DEPTH + 1);
    localparam int TMO_TICKS = TMO_BITS * OS;
    localparam logic [5:0] DEPTH6 = 6'(DEPTH);

    logic          line, rx_idle, brk_hold;
    logic          frm_valid, frm_err, frm_brk;
    logic [7:0]    frm_data;
    rx_entry_t     head;
    logic [CW-1:0] fifo_count, trig_eff;
    logic          full, empty, push, pop, ovr_ev;
    logic [3:0]    stat;
    logic          rdf, dr, er, brk, orer;
    logic [5:0]    trig_q;
    logic          rie_q, eie_q;
    logic [7:0]    last_q;
    logic          rd_any, wr_any;

    assign rd_any = bus_sel && !bus_wr;
    assign wr_any = bus_sel &&  bus_wr;
    assign push   = frm_valid && !full;
    assign ovr_ev = frm_valid &&  full;
    assign pop    = rd_any && (bus_addr == A_DATA) && !empty;
    assign {brk, er, dr, rdf} = stat;

    uart_rx_deser #(.OS(OS)) u_deser (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rxd(rxd),
        .line(line), .rx_idle(rx_idle), .brk_hold(brk_hold),
        .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_err(frm_err), .frm_brk(frm_brk)
    );

    uart_rx_fifo #(.DEPTH(DEPTH), .W($bits(rx_entry_t))) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din({frm_err, frm_data}),
        .pop(pop), .head(head), .count(fifo_count), .full(full), .empty(empty)
    );

    uart_rx_flags #(.CW(CW), .TMO_TICKS(TMO_TICKS)) u_flags (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rx_idle(rx_idle),
        .frm_valid(frm_valid), .frm_err(frm_err), .frm_brk(frm_brk),
        .ovr_ev(ovr_ev), .fifo_count(fifo_count), .trig_eff(trig_eff),
        .st_rd(rd_any && bus_addr == A_STAT),
        .st_wr(wr_any && bus_addr == A_STAT), .st_wbits(bus_wdata[3:0]),
        .ls_rd(rd_any && bus_addr == A_LSTAT),
        .ls_wr(wr_any && bus_addr == A_LSTAT), .ls_wbit(bus_wdata[0]),
        .stat(stat), .orer(orer)
    );

    // Trigger clamped to the range 1..DEPTH.
    always_comb begin
        if (trig_q == '0)         trig_eff = CW'(1);
        else if (trig_q >= DEPTH6) trig_eff = CW'(DEPTH);
        else                      trig_eff = trig_q[CW-1:0];
    end

    // Control register and the last popped character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 6'd1;
            rie_q  <= 1'b0;
            eie_q  <= 1'b0;
            last_q <= '0;
        end else begin
            if (wr_any && bus_addr == A_CTRL) begin
                trig_q <= bus_wdata[5:0];
                eie_q  <= bus_wdata[6];
                rie_q  <= bus_wdata[7];
            end
            if (pop) last_q <= head.data;
        end
    end

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA:  bus_rdata = empty ? last_q : head.data;
            A_STAT:  bus_rdata = {line, 2'b00, !empty && head.err, stat};
            A_LSTAT: bus_rdata[0] = orer;
            A_COUNT: bus_rdata[CW-1:0] = fifo_count;
            A_CTRL:  bus_rdata = {rie_q, eie_q, trig_q};
            default: bus_rdata = '0;
        endcase
    end

    // Interrupt combine.
    always_comb irq = (rie_q && (rdf || dr)) || (eie_q && (er || brk || orer));
endmodule

// File: rtl/serial_rx_fifo_ctl_chk.sv
// Checker for serial_rx_fifo_ctl, attached by bind below.
module serial_rx_fifo_ctl_chk #(
    parameter int CW    = 5,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [2:0]    bus_addr,
    input logic [7:0]    bus_wdata,
    input logic [CW-1:0] fifo_count,
    input logic          push,
    input logic          pop,
    input logic          ovr_ev,
    input logic          brk_hold,
    input logic          rdf,
    input logic          orer
);
    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R7
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_ev && !pop) |=> (fifo_count == $past(fifo_count)) && orer);

    // R3
    rdf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdf) |-> $past(bus_sel && bus_wr && bus_addr == 3'd1 && !bus_wdata[0]));

    // R12
    orer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(orer) |-> $past(bus_sel && bus_wr && bus_addr == 3'd2 && !bus_wdata[0]));

    // R6
    brk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_hold && $past(brk_hold)) |-> !push);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 3'd0 && fifo_count == '0) |=> fifo_count <= CW'(1));
endmodule

bind serial_rx_fifo_ctl serial_rx_fifo_ctl_chk #(.CW(CW), .DEPTH(DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .fifo_count(fifo_count),
    .push(push), .pop(pop), .ovr_ev(ovr_ev), .brk_hold(brk_hold),
    .rdf(rdf), .orer(orer)
);

// File: tb/test_serial_rx_fifo_ctl.sv
module test_serial_rx_fifo_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] q[$];
    logic [7:0] last_val = 8'h00;

    always #4 clk = ~clk;

    serial_rx_fifo_ctl i_serial_rx_fifo_ctl (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] pack_status(bit rdy, bit tmo, bit fe, bit bk, bit herr, bit ln);
        return {ln, 2'b00, herr, bk, fe, tmo, rdy};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(logic lvl, int n);
        rxd = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(logic [7:0] b, logic stopv);
        @(negedge clk);
        hold(1'b0, 16);
        for (int i = 0; i < 8; i++) hold(b[i], 16);
        hold(stopv, 16);
        hold(1'b1, 16);
    endtask

    task automatic bus_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(logic [2:0] a, logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic data_read(string req);
        logic [7:0] d, e;
        bus_read(3'd0, d);
        e = (q.size() > 0) ? q.pop_front() : last_val;
        last_val = e;
        check(req, d, e);
    endtask

    task automatic flush();
        logic [7:0] c;
        bus_read(3'd3, c);
        check("R9 count before drain", c, q.size());
        for (int i = 0; i < int'(c); i++) data_read("R1 drained order");
    endtask

    task automatic clear_all();
        logic [7:0] d;
        bus_read(3'd1, d); bus_write(3'd1, 8'h00);
        bus_read(3'd2, d); bus_write(3'd2, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] b;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Reset state (R13, R11, R9, R4)
        bus_read(3'd1, d); check("R11 reset status", d, pack_status(0,0,0,0,0,1));
        bus_read(3'd3, d); check("R9 reset count", d, 0);
        bus_read(3'd2, d); check("R7 reset line status", d, 0);
        bus_read(3'd4, d); check("R13 reset control", d, 8'h01);
        check("R4 reset irq", irq, 0);

        // Glitch shorter than half a bit: line bit low, no start (R11, R2)
        @(negedge clk); rxd = 1'b0;
        repeat (2) @(negedge clk);
        bus_read(3'd1, d);
        rxd = 1'b1;
        check("R11 line low seen", d[7], 0);
        repeat (40) @(negedge clk);
        bus_read(3'd3, d); check("R2 false start queues nothing", d, 0);

        // Ready flag, trigger, irq and read-then-clear (R3, R4, R12)
        bus_write(3'd4, 8'h84);
        for (int i = 0; i < 3; i++) begin
            b = 8'($urandom); q.push_back(b); send_frame(b, 1'b1);
        end
        bus_read(3'd1, d); check("R3 below trigger", d[0], 0);
        check("R4 irq low below trigger", irq, 0);
        b = 8'($urandom); q.push_back(b); send_frame(b, 1'b1);
        check("R4 irq on ready", irq, 1);
        bus_read(3'd1, d); check("R3 ready at trigger", d[0], 1);
        bus_write(3'd1, 8'h00);
        repeat (2) @(negedge clk);
        check("R3 clear overridden while at trigger", irq, 1);
        for (int i = 0; i < 4; i++) data_read("R1 order after trigger");
        check("R3 ready sticky after drain", irq, 1);
        bus_write(3'd1, 8'h00);
        repeat (2) @(negedge clk);
        check("R12 write 0 without read keeps ready", irq, 1);
        bus_read(3'd1, d); check("R3 still set", d[0], 1);
        bus_write(3'd1, 8'h00);
        repeat (2) @(negedge clk);
        check("R12 armed clear drops irq", irq, 0);
        bus_read(3'd1, d); check("R12 ready cleared", d[0], 0);

        // Trigger 0 acts as 1 (R3)
        bus_write(3'd4, 8'h00);
        b = 8'($urandom); q.push_back(b); send_frame(b, 1'b1);
        bus_read(3'd1, d); check("R3 trigger zero acts as one", d[0], 1);
        flush(); clear_all();

        // Timeout flag (R8)
        bus_write(3'd4, 8'h04);
        for (int i = 0; i < 2; i++) begin
            b = 8'($urandom); q.push_back(b); send_frame(b, 1'b1);
        end
        bus_read(3'd1, d); check("R8 no timeout yet", d[1], 0);
        repeat (260) @(negedge clk);
        bus_read(3'd1, d); check("R8 timeout after quiet line", d, pack_status(0,1,0,0,0,1));
        flush(); clear_all();

        // Framing error, error irq, clear rules (R5, R4, R12)
        bus_write(3'd4, 8'h50);
        q.push_back(8'hA5); send_frame(8'hA5, 1'b0);
        check("R4 error irq", irq, 1);
        bus_write(3'd1, 8'h00);
        bus_read(3'd1, d); check("R5 framing error status", d, pack_status(0,0,1,0,1,1));
        bus_write(3'd1, 8'hFF);
        bus_read(3'd1, d); check("R12 write 1 keeps error", d[2], 1);
        bus_write(3'd1, 8'h00);
        bus_read(3'd1, d); check("R12 armed clear of error", d[2], 0);
        check("R4 error irq cleared", irq, 0);
        bus_read(3'd3, d); check("R9 count after framing error", d, 1);
        flush(); clear_all();

        // Break (R6)
        bus_write(3'd4, 8'h10);
        @(negedge clk);
        hold(1'b0, 320);
        hold(1'b1, 32);
        q.push_back(8'h00);
        bus_read(3'd3, d); check("R6 single byte for break", d, 1);
        bus_read(3'd1, d); check("R6 break status", d, pack_status(0,0,1,1,1,1));
        flush(); clear_all();
        bus_read(3'd1, d); check("R5 head error empty", d[4], 0);

        // Empty reads (R10)
        data_read("R10 empty read returns last");
        data_read("R10 empty read repeat");
        bus_read(3'd3, d); check("R10 count stays zero", d, 0);

        // Overrun (R7, R12)
        for (int i = 0; i < 16; i++) begin
            b = 8'($urandom); q.push_back(b); send_frame(b, 1'b1);
        end
        send_frame(8'h3C, 1'b1);
        bus_read(3'd3, d); check("R7 count held at depth", d, 16);
        bus_write(3'd2, 8'h00);
        bus_read(3'd2, d); check("R12 overrun kept without read", d, 1);
        bus_write(3'd2, 8'h00);
        bus_read(3'd2, d); check("R12 overrun cleared", d, 0);
        flush(); clear_all();

        // Random traffic against the queue model (R1, R9)
        for (int it = 0; it < 60; it++) begin
            if (($urandom % 3) != 0 && q.size() < 16) begin
                b = 8'($urandom); q.push_back(b); send_frame(b, 1'b1);
            end else begin
                data_read("R1 random order");
            end
            repeat ($urandom % 20) @(negedge clk);
        end
        bus_read(3'd3, d); check("R9 random count", d, q.size());

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule